// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block sits beside a small 8-bit CPU core and takes over the memory traffic that interrupt entry and return need. The core shows it the raw request lines, their local enables and its current register file: program counter, two 16-bit index registers, two accumulators, condition codes and stack pointer. When an instruction finishes and a request is allowed through, the sequencer writes the whole register context to the stack, one byte per cycle. It then hands back a condition-code value with the mask bits raised and a lowered stack pointer. Finally it reads the two-byte vector of the winning source and presents the new program counter.

On a return command it reads the nine saved bytes back in the reverse order and presents every restored register at once, together with the raised stack pointer. The core loads the values on the given strobes. The memory port is a single byte-wide port with a write enable and a read strobe. Read data must be valid in the same cycle as the read strobe.

Top module: `irq_ctx_seq`

## Requirements
- R1: A maskable source k is pending only when irq_req[k] and irq_en[k] are both 1 and condition-code bit 4 (the I mask) is 0. The non-maskable line xirq_req is pending only when condition-code bit 6 (the X mask) is 0. Entry starts only in a cycle where the block is idle, insn_done is 1 and some source is pending; otherwise no memory access takes place.
- R2: Entry performs nine write cycles, starting the cycle after recognition, to addresses SP, SP-1, …, SP-8. The bytes written are, in that order: PC low, PC high, IY low, IY high, IX low, IX high, A, B, CCR.
- R3: The CCR byte written to the stack is the condition-code value from the recognition cycle, without any mask change.
- R4: In the cycle after the CCR write, ccr_load is 1 and ccr_o equals the saved CCR with bit 4 set, and with bit 6 also set when the non-maskable line won. In the same cycle sp_load is 1 and sp_o equals SP-9.
- R5: The non-maskable line outranks every maskable source, and among maskable sources a lower index outranks a higher one. The winner's vector high byte is read at VEC_BASE for the non-maskable line and at VEC_BASE+2(k+1) for source k. The low byte is read at the next address, in the cycle after the high byte.
- R6: In the cycle after the low vector byte is read, pc_load is 1 and pc_o equals {high byte, low byte}.
- R7: When the block is idle and rti_req is 1, it performs nine read cycles at SP+1 … SP+9, taking in CCR, B, A, IX high, IX low, IY high, IY low, PC high and PC low in that order. In the following cycle ctx_load, pc_load, ccr_load and sp_load are all 1, the restored registers are on their outputs, and sp_o equals SP+9.
- R8: busy is 1 from the cycle after recognition until the cycle of the final load: 12 cycles for an entry and 10 for a return. Requests, insn_done and rti_req have no effect while busy is 1.
- R9: mem_we and mem_re are never 1 together, and neither is 1 while busy is 0.
- R10: When rti_req and a recognizable interrupt arrive in the same idle cycle, the return is performed and no write takes place.
- R11: After reset, busy, every load strobe, mem_we and mem_re are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC | Maskable request lines, index 0 highest priority |
| irq_en | input | N_SRC | Local enable per maskable source |
| xirq_req | input | 1 | Non-maskable request line, gated only by CCR bit 6 |
| insn_done | input | 1 | Strobe marking an instruction boundary |
| rti_req | input | 1 | Return-from-interrupt command |
| pc_i | input | 16 | Current program counter |
| ix_i | input | 16 | Current index register X |
| iy_i | input | 16 | Current index register Y |
| acca_i | input | 8 | Current accumulator A |
| accb_i | input | 8 | Current accumulator B |
| ccr_i | input | 8 | Current condition codes |
| sp_i | input | 16 | Current stack pointer |
| mem_addr | output | 16 | Byte address of the memory access |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the cycle of mem_re |
| busy | output | 1 | Sequence in progress |
| pc_o | output | 16 | Program counter to load |
| pc_load | output | 1 | Load strobe for pc_o |
| ccr_o | output | 8 | Condition codes to load |
| ccr_load | output | 1 | Load strobe for ccr_o |
| sp_o | output | 16 | Stack pointer to load |
| sp_load | output | 1 | Load strobe for sp_o |
| ix_o | output | 16 | Restored index register X |
| iy_o | output | 16 | Restored index register Y |
| acca_o | output | 8 | Restored accumulator A |
| accb_o | output | 8 | Restored accumulator B |
| ctx_load | output | 1 | Load strobe for the restored IX, IY, A and B |

## Verification
The address-step checks assume that a read or write burst stays inside one sequence. They also assume the stack pointer given at the start does not wrap within the nine bytes. The stimulus keeps the stack well inside the address space and away from the vector area. The busy and start checks assume insn_done or rti_req is the only thing that can launch a sequence. The bench therefore changes every input on the falling edge and releases all requests before a running sequence ends. This keeps a held request from restarting the block unseen. Read data comes from a bench memory that answers in the same cycle, which the vector and restore paths depend on.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int CTX_BYTES = 9;
    localparam int CTX_W     = CTX_BYTES * BYTE_W;
    localparam int CNT_W     = $clog2(CTX_BYTES + 1);
    localparam int CCR_I_BIT = 4;
    localparam int CCR_X_BIT = 6;

    // byte slots of the packed context, in stack push order
    localparam int SLOT_PCL = 0;
    localparam int SLOT_PCH = 1;
    localparam int SLOT_IYL = 2;
    localparam int SLOT_IXL = 4;
    localparam int SLOT_A   = 6;
    localparam int SLOT_B   = 7;
    localparam int SLOT_CCR = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_PULL,
        ST_FIN
    } seq_state_e;
endpackage

// File: rtl/irq_src_pick.sv
module irq_src_pick
    import irq_ctx_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]  req_i,
    input  logic [N_SRC-1:0]  en_i,
    input  logic              xreq_i,
    input  logic [BYTE_W-1:0] ccr_i,
    output logic              hit_o,
    output logic              x_win_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [N_SRC-1:0] pend;
    logic             x_pend;

    always_comb begin
        pend   = req_i & en_i & {N_SRC{~ccr_i[CCR_I_BIT]}};
        x_pend = xreq_i & ~ccr_i[CCR_X_BIT];
        idx_o  = '0;
        // scan from the lowest rank upward so the lowest index wins
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (pend[k]) begin
                idx_o = IDX_W'(k);
            end
        end
        x_win_o = x_pend;
        hit_o   = x_pend | (|pend);
    end
endmodule

// File: rtl/irq_ctx_pack.sv
module irq_ctx_pack
    import irq_ctx_pkg::*;
(
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] ix_i,
    input  logic [ADDR_W-1:0] iy_i,
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic [BYTE_W-1:0] ccr_i,
    output logic [CTX_W-1:0]  ctx_o
);
    // slot 0 at the bottom: PCL, PCH, IYL, IYH, IXL, IXH, A, B, CCR
    assign ctx_o = {ccr_i, b_i, a_i, ix_i, iy_i, pc_i};
endmodule

// File: rtl/irq_byte_sel.sv
module irq_byte_sel
    import irq_ctx_pkg::*;
#(
    parameter int NB = CTX_BYTES,
    parameter int W  = BYTE_W,
    localparam int SEL_W = $clog2(NB + 1)
) (
    input  logic [NB*W-1:0] flat_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     byte_o
);
    logic [W-1:0] lanes [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = flat_i[g*W +: W];
    end

    always_comb begin
        byte_o = '0;
        for (int g = 0; g < NB; g++) begin
            if (sel_i == SEL_W'(g)) begin
                byte_o = lanes[g];
            end
        end
    end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int              N_SRC    = 8,
    parameter logic [15:0]     VEC_BASE = 16'hFFC0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    irq_req,
    input  logic [N_SRC-1:0]    irq_en,
    input  logic                xirq_req,
    input  logic                insn_done,
    input  logic                rti_req,
    input  logic [15:0]         pc_i,
    input  logic [15:0]         ix_i,
    input  logic [15:0]         iy_i,
    input  logic [7:0]          acca_i,
    input  logic [7:0]          accb_i,
    input  logic [7:0]          ccr_i,
    input  logic [15:0]         sp_i,
    output logic [15:0]         mem_addr,
    output logic [7:0]          mem_wdata,
    output logic                mem_we,
    output logic                mem_re,
    input  logic [7:0]          mem_rdata,
    output logic                busy,
    output logic [15:0]         pc_o,
    output logic                pc_load,
    output logic [7:0]          ccr_o,
    output logic                ccr_load,
    output logic [15:0]         sp_o,
    output logic                sp_load,
    output logic [15:0]         ix_o,
    output logic [15:0]         iy_o,
    output logic [7:0]          acca_o,
    output logic [7:0]          accb_o,
    output logic                ctx_load
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CTX_BYTES - 1);
    localparam logic [ADDR_W-1:0] SP_SPAN = ADDR_W'(CTX_BYTES);

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [CTX_W-1:0]   ctx;
        logic [ADDR_W-1:0]  sp;
        logic               xwin;
        logic [IDX_W-1:0]   src;
        logic [BYTE_W-1:0]  vhi;
        logic [ADDR_W-1:0]  pc_out;
        logic [BYTE_W-1:0]  ccr_out;
        logic [ADDR_W-1:0]  sp_out;
        logic               ld_pc;
        logic               ld_ccr;
        logic               ld_sp;
        logic               ld_ctx;
        logic               busy;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic              hit;
    logic              x_win;
    logic [IDX_W-1:0]  win_idx;
    logic [CTX_W-1:0]  live_ctx;
    logic [BYTE_W-1:0] push_byte;
    logic [ADDR_W-1:0] vec_addr;
    logic [CNT_W-1:0]  pull_slot;
    logic [BYTE_W-1:0] saved_ccr;

    irq_src_pick #(.N_SRC(N_SRC)) u_pick (
        .req_i   (irq_req),
        .en_i    (irq_en),
        .xreq_i  (xirq_req),
        .ccr_i   (ccr_i),
        .hit_o   (hit),
        .x_win_o (x_win),
        .idx_o   (win_idx)
    );

    irq_ctx_pack u_pack (
        .pc_i  (pc_i),
        .ix_i  (ix_i),
        .iy_i  (iy_i),
        .a_i   (acca_i),
        .b_i   (accb_i),
        .ccr_i (ccr_i),
        .ctx_o (live_ctx)
    );

    irq_byte_sel #(.NB(CTX_BYTES), .W(BYTE_W)) u_sel (
        .flat_i (r_q.ctx),
        .sel_i  (r_q.cnt),
        .byte_o (push_byte)
    );

    assign saved_ccr = r_q.ctx[SLOT_CCR*BYTE_W +: BYTE_W];
    assign pull_slot = LAST_CNT - r_q.cnt;
    assign vec_addr  = r_q.xwin ? VEC_BASE
                     : VEC_BASE + ADDR_W'({r_q.src, 1'b0}) + ADDR_W'(2);

    // memory port driven straight from the state
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (r_q.st)
            ST_PUSH: begin
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - ADDR_W'(r_q.cnt);
                mem_wdata = push_byte;
            end
            ST_PULL: begin
                mem_re   = 1'b1;
                mem_addr = r_q.sp + ADDR_W'(r_q.cnt) + ADDR_W'(1);
            end
            ST_VEC_HI: begin
                mem_re   = 1'b1;
                mem_addr = vec_addr;
            end
            ST_VEC_LO: begin
                mem_re   = 1'b1;
                mem_addr = vec_addr + ADDR_W'(1);
            end
            default: ;
        endcase
    end

    always_comb begin
        r_d        = r_q;
        r_d.ld_pc  = 1'b0;
        r_d.ld_ccr = 1'b0;
        r_d.ld_sp  = 1'b0;
        r_d.ld_ctx = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (rti_req) begin
                    r_d.st   = ST_PULL;
                    r_d.cnt  = '0;
                    r_d.sp   = sp_i;
                    r_d.busy = 1'b1;
                end else if (insn_done && hit) begin
                    r_d.st   = ST_PUSH;
                    r_d.cnt  = '0;
                    r_d.sp   = sp_i;
                    r_d.ctx  = live_ctx;
                    r_d.xwin = x_win;
                    r_d.src  = win_idx;
                    r_d.busy = 1'b1;
                end
            end
            ST_PUSH: begin
                if (r_q.cnt == LAST_CNT) begin
                    r_d.st      = ST_VEC_HI;
                    r_d.ld_ccr  = 1'b1;
                    r_d.ccr_out = saved_ccr;
                    r_d.ccr_out[CCR_I_BIT] = 1'b1;
                    if (r_q.xwin) begin
                        r_d.ccr_out[CCR_X_BIT] = 1'b1;
                    end
                    r_d.ld_sp   = 1'b1;
                    r_d.sp_out  = r_q.sp - SP_SPAN;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_VEC_HI: begin
                r_d.vhi = mem_rdata;
                r_d.st  = ST_VEC_LO;
            end
            ST_VEC_LO: begin
                r_d.pc_out = {r_q.vhi, mem_rdata};
                r_d.ld_pc  = 1'b1;
                r_d.st     = ST_FIN;
            end
            ST_PULL: begin
                r_d.ctx[{pull_slot, 3'b000} +: BYTE_W] = mem_rdata;
                if (r_q.cnt == LAST_CNT) begin
                    r_d.st      = ST_FIN;
                    r_d.pc_out  = {r_q.ctx[SLOT_PCH*BYTE_W +: BYTE_W], mem_rdata};
                    r_d.ccr_out = saved_ccr;
                    r_d.sp_out  = r_q.sp + SP_SPAN;
                    r_d.ld_pc   = 1'b1;
                    r_d.ld_ccr  = 1'b1;
                    r_d.ld_sp   = 1'b1;
                    r_d.ld_ctx  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_FIN: begin
                r_d.st   = ST_IDLE;
                r_d.busy = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = r_q.busy;
    assign pc_o     = r_q.pc_out;
    assign pc_load  = r_q.ld_pc;
    assign ccr_o    = r_q.ccr_out;
    assign ccr_load = r_q.ld_ccr;
    assign sp_o     = r_q.sp_out;
    assign sp_load  = r_q.ld_sp;
    assign ctx_load = r_q.ld_ctx;
    assign ix_o     = r_q.ctx[SLOT_IXL*BYTE_W +: 2*BYTE_W];
    assign iy_o     = r_q.ctx[SLOT_IYL*BYTE_W +: 2*BYTE_W];
    assign acca_o   = r_q.ctx[SLOT_A*BYTE_W +: BYTE_W];
    assign accb_o   = r_q.ctx[SLOT_B*BYTE_W +: BYTE_W];

    // one memory access at a time, none while idle
    assert_single_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re));
    // consecutive pushes walk down by one byte
    assert_push_descends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));
    // consecutive reads (pull or vector) walk up by one byte
    assert_read_ascends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 16'd1));
    // entry mask update always raises I
    assert_entry_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_load && !ctx_load) |-> ccr_o[CCR_I_BIT]);
    // a return loads the whole register set together
    assert_restore_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |-> (pc_load && ccr_load && sp_load));
    // busy only starts from a boundary or a return command
    assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_done || rti_req));
    // busy ends right after the final program counter load
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(pc_load));
endmodule

// File: tb/test_irq_ctx_seq.sv
`timescale 1ns/1ps
module test_irq_ctx_seq;
    localparam int N_SRC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_SRC-1:0] irq_req = '0, irq_en = '0;
    logic xirq_req = 1'b0, insn_done = 1'b0, rti_req = 1'b0;
    logic [15:0] pc_i = '0, ix_i = '0, iy_i = '0, sp_i = '0;
    logic [7:0]  acca_i = '0, accb_i = '0, ccr_i = '0;
    logic [15:0] mem_addr, pc_o, sp_o, ix_o, iy_o;
    logic [7:0]  mem_wdata, mem_rdata, ccr_o, acca_o, accb_o;
    logic mem_we, mem_re, busy, pc_load, ccr_load, sp_load, ctx_load;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_ctx_seq #(.N_SRC(N_SRC), .VEC_BASE(16'hFFC0)) i_irq_ctx_seq (
        .clk, .rst_n, .irq_req, .irq_en, .xirq_req, .insn_done, .rti_req,
        .pc_i, .ix_i, .iy_i, .acca_i, .accb_i, .ccr_i, .sp_i,
        .mem_addr, .mem_wdata, .mem_we, .mem_re, .mem_rdata,
        .busy, .pc_o, .pc_load, .ccr_o, .ccr_load, .sp_o, .sp_load,
        .ix_o, .iy_o, .acca_o, .accb_o, .ctx_load
    );

    // byte memory folded onto 256 locations; vectors sit at C0..D1
    logic [7:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];

    function automatic logic [15:0] vec_val(input bit xw, input int k);
        return xw ? 16'hBEEF : {8'(8'hA0 + k), 8'(8'h10 + k)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) mem[a] <= 8'h00;
            mem[8'hC0] <= 8'hBE;
            mem[8'hC1] <= 8'hEF;
            for (int k = 0; k < N_SRC; k++) begin
                mem[8'(8'hC2 + 2*k)] <= 8'(8'hA0 + k);
                mem[8'(8'hC3 + 2*k)] <= 8'(8'h10 + k);
            end
        end else if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    // monitor, sampled on the falling edge
    logic [15:0] wa [0:31];
    logic [7:0]  wd [0:31];
    logic [15:0] ra [0:31];
    int wn, rn, busy_n, n_pc, n_ccr, n_sp, n_ctx;
    logic [15:0] c_pc, c_sp, c_ix, c_iy;
    logic [7:0]  c_ccr, c_a, c_b;
    bit both_we_re;

    task automatic clear_log();
        wn = 0; rn = 0; busy_n = 0; n_pc = 0; n_ccr = 0; n_sp = 0; n_ctx = 0;
        both_we_re = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we && wn < 32) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; wn++; end
            if (mem_re && rn < 32) begin ra[rn] = mem_addr; rn++; end
            if (mem_we && mem_re) both_we_re = 1'b1;
            if (busy) busy_n++;
            if (pc_load) begin c_pc = pc_o; n_pc++; end
            if (ccr_load) begin c_ccr = ccr_o; n_ccr++; end
            if (sp_load) begin c_sp = sp_o; n_sp++; end
            if (ctx_load) begin
                c_ix = ix_o; c_iy = iy_o; c_a = acca_o; c_b = accb_o; n_ctx++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_regs(input logic [15:0] pc, ix, iy, input logic [7:0] a, b,
                            input logic [7:0] ccr, input logic [15:0] sp);
        pc_i = pc; ix_i = ix; iy_i = iy; acca_i = a; accb_i = b; ccr_i = ccr; sp_i = sp;
    endtask

    // one instruction boundary with the given request pattern, then drain
    task automatic pulse_boundary(input logic [N_SRC-1:0] rq, en, input bit x, input bit rti);
        @(negedge clk);
        irq_req = rq; irq_en = en; xirq_req = x; insn_done = 1'b1; rti_req = rti;
        @(negedge clk);
        irq_req = '0; irq_en = '0; xirq_req = 1'b0; insn_done = 1'b0; rti_req = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    task automatic t_reset();
        check(!busy, "R11 busy", 32'(busy), 0);
        check(!(pc_load || ccr_load || sp_load || ctx_load), "R11 loads",
              32'({pc_load, ccr_load, sp_load, ctx_load}), 0);
        check(!(mem_we || mem_re), "R11 mem", 32'({mem_we, mem_re}), 0);
    endtask

    // full entry check against values derived from the requirements
    task automatic t_entry(input string tag, input logic [15:0] pc, ix, iy,
                           input logic [7:0] a, b, ccr, input logic [15:0] sp,
                           input logic [N_SRC-1:0] rq, en, input bit x,
                           input bit exp_x, input int exp_k, input bit noise);
        logic [7:0] eb [0:8];
        logic [7:0] eccr;
        logic [15:0] vaddr;
        bit ok;
        eb[0] = pc[7:0]; eb[1] = pc[15:8]; eb[2] = iy[7:0]; eb[3] = iy[15:8];
        eb[4] = ix[7:0]; eb[5] = ix[15:8]; eb[6] = a; eb[7] = b; eb[8] = ccr;
        eccr = ccr | 8'h10 | (exp_x ? 8'h40 : 8'h00);
        vaddr = exp_x ? 16'hFFC0 : 16'(16'hFFC0 + 2 * (exp_k + 1));
        set_regs(pc, ix, iy, a, b, ccr, sp);
        clear_log();
        @(negedge clk);
        irq_req = rq; irq_en = en; xirq_req = x; insn_done = 1'b1;
        @(negedge clk);
        irq_req = '0; irq_en = '0; xirq_req = 1'b0; insn_done = 1'b0;
        set_regs(16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'hFF, 16'h0);
        if (noise) begin
            // R8: stimulus while busy must change nothing
            repeat (3) @(negedge clk);
            xirq_req = 1'b1; irq_req = '1; irq_en = '1; insn_done = 1'b1; rti_req = 1'b1;
            repeat (4) @(negedge clk);
            xirq_req = 1'b0; irq_req = '0; irq_en = '0; insn_done = 1'b0; rti_req = 1'b0;
        end
        repeat (16) @(negedge clk);
        check(wn == 9, {"R2 write count ", tag}, 32'(wn), 9);
        ok = 1'b1;
        for (int i = 0; i < 9; i++)
            if (wa[i] != 16'(sp - i) || wd[i] != eb[i]) ok = 1'b0;
        check(ok, {"R2 push order ", tag}, {wa[0], 8'h0, wd[0]}, {sp, 8'h0, eb[0]});
        check(wn > 8 && wd[8] == ccr, {"R3 saved ccr ", tag}, 32'(wd[8]), 32'(ccr));
        check(n_ccr == 1 && c_ccr == eccr, {"R4 ccr mask ", tag}, 32'(c_ccr), 32'(eccr));
        check(n_sp == 1 && c_sp == 16'(sp - 9), {"R4 sp ", tag}, 32'(c_sp), 32'(sp - 9));
        check(rn == 2 && ra[0] == vaddr && ra[1] == 16'(vaddr + 1),
              {"R5 vector addr ", tag}, {ra[0], ra[1]}, {vaddr, 16'(vaddr + 1)});
        check(n_pc == 1 && c_pc == vec_val(exp_x, exp_k), {"R6 vector pc ", tag},
              32'(c_pc), 32'(vec_val(exp_x, exp_k)));
        check(busy_n == 12 && n_ctx == 0, {"R8 busy length ", tag}, 32'(busy_n), 12);
        check(!both_we_re, {"R9 access ", tag}, 32'(both_we_re), 0);
    endtask

    task automatic t_return(input string tag, input logic [15:0] sp,
                            input logic [15:0] pc, ix, iy, input logic [7:0] a, b, ccr,
                            input bit with_irq);
        bit ok;
        set_regs(16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h00, sp);
        clear_log();
        pulse_boundary(with_irq ? 8'h01 : 8'h00, '1, 1'b0, 1'b1);
        check(wn == 0, {"R10 no write on return ", tag}, 32'(wn), 0);
        ok = (rn == 9);
        for (int i = 0; i < 9; i++) if (ra[i] != 16'(sp + 1 + i)) ok = 1'b0;
        check(ok, {"R7 pull addresses ", tag}, {ra[0], ra[8]}, {16'(sp + 1), 16'(sp + 9)});
        check(n_ctx == 1 && n_pc == 1 && c_pc == pc && c_ccr == ccr,
              {"R7 pc/ccr ", tag}, {c_pc, 8'h0, c_ccr}, {pc, 8'h0, ccr});
        check(c_ix == ix && c_iy == iy && c_a == a && c_b == b, {"R7 regs ", tag},
              {c_ix, c_a, c_b}, {ix, a, b});
        check(c_sp == 16'(sp + 9) && busy_n == 10, {"R7 R8 sp/busy ", tag},
              {c_sp, 16'(busy_n)}, {16'(sp + 9), 16'd10});
    endtask

    task automatic t_no_start(input string tag, input logic [N_SRC-1:0] rq, en,
                              input bit x, input logic [7:0] ccr, input bit boundary);
        set_regs(16'h4321, 16'h1, 16'h2, 8'h3, 8'h4, ccr, 16'h0150);
        clear_log();
        @(negedge clk);
        irq_req = rq; irq_en = en; xirq_req = x; insn_done = boundary;
        repeat (4) @(negedge clk);
        irq_req = '0; irq_en = '0; xirq_req = 1'b0; insn_done = 1'b0;
        repeat (4) @(negedge clk);
        check(busy_n == 0 && wn == 0 && rn == 0, {"R1 no start ", tag},
              {16'(busy_n), 8'(wn), 8'(rn)}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // maskable source 2 beats 5, I and X clear
        t_entry("m2", 16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'h05, 16'h01FF,
                8'b0010_0100, '1, 1'b0, 1'b0, 2, 1'b0);
        t_return("m2", 16'h01F6, 16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'h05, 1'b0);
        // non-maskable wins while I is set
        t_entry("x", 16'hCAFE, 16'h0102, 16'h0304, 8'h55, 8'h66, 8'h10, 16'h00A0,
                8'b1000_0001, '1, 1'b1, 1'b1, 0, 1'b0);
        t_return("x", 16'h0097, 16'hCAFE, 16'h0102, 16'h0304, 8'h55, 8'h66, 8'h10, 1'b0);
        // X set hides the non-maskable line; source 5 enabled, source 1 not (R5, R1)
        t_entry("xmask", 16'h0F0F, 16'hAAAA, 16'h5555, 8'h01, 8'h02, 8'h41, 16'h0080,
                8'b0010_0010, 8'b0010_0000, 1'b1, 1'b0, 5, 1'b0);
        // busy ignores new requests and commands (R8)
        t_entry("busy", 16'h7777, 16'h8888, 16'h9999, 8'hAB, 8'hCD, 8'h00, 16'h0070,
                8'b0000_0001, 8'b0000_0001, 1'b0, 1'b0, 0, 1'b1);
        // return beats a pending interrupt at the same boundary (R10)
        t_return("prec", 16'h0067, 16'h7777, 16'h8888, 16'h9999, 8'hAB, 8'hCD, 8'h00, 1'b1);
        t_no_start("Imask", 8'hFF, 8'hFF, 1'b0, 8'h10, 1'b1);
        t_no_start("noen", 8'hFF, 8'h00, 1'b0, 8'h00, 1'b1);
        t_no_start("Xmask", 8'h00, 8'hFF, 1'b1, 8'h40, 1'b1);
        t_no_start("noboundary", 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule